// File: doc/BRIEF.md
# Three-Level DMA Address Translation Walker

This block turns a device DMA address into the physical address of a 4 KiB page. It walks three levels of 64-bit table entries that sit in memory: first a region table, then a segment table, then a page table. Each lookup is a single read through a simple request/response memory port. The walker takes one request at a time. It reports its result with a one-cycle `done` pulse, which carries the page address, an offset mask and a permission that is either none or read-write.

Two conditions must hold before the walk starts. The function must be in a state that allows translation, and the translation enable must be set. The address must also lie inside an inclusive window. If either condition fails, the walker returns a fault and never touches memory. At each intermediate level it checks the entry's type field before it follows the pointer. A mismatch, or a page entry that is all zero, ends the walk with a fault result and raises no exception.

Top module: `dma_xlate_walker`

## Requirements
- R1: `req_ready` is high only when the walker is idle. A request is accepted when `req_valid` and `req_ready` are both high at a clock edge. `req_ready` then stays low until the cycle after `done`.
- R2: The function state is encoded as 0 standby, 1 disabled, 2 enabled and 3 blocked. A walk starts only in state 2 or 3 with `xlate_en` high. Otherwise the result is a fault and no memory read is made.
- R3: If `req_addr` is below `win_lo` or above `win_hi`, the result is a fault with no memory read. Both bounds are inclusive, so an address equal to a bound is translated.
- R4: Bits [11:0] of `origin` are ignored. The region entry is read at (origin with bits [11:0] cleared) + 8 × `req_addr[41:31]`. Every read address is 8-byte aligned.
- R5: The region entry is followed only if its bits [3:2] equal 2'b11. Otherwise the walk ends as a fault after exactly one read. When it is followed, the segment entry is read at (region entry with bits [11:0] cleared) + 8 × `req_addr[30:20]`.
- R6: The segment entry is followed only if its bits [3:2] equal 2'b10. Otherwise the walk ends as a fault after exactly two reads. When it is followed, the page entry is read at (segment entry with bits [11:0] cleared) + 8 × `req_addr[19:12]`.
- R7: A page entry of all zeros gives a fault result.
- R8: A nonzero page entry gives `res_page` equal to that entry with bits [11:0] cleared, and `res_mask` equal to 0xFFF. `res_rw` is 1 when entry bit 10 is clear and 0 when bit 10 is set.
- R9: A fault result has `res_page` = 0, `res_mask` = all ones and `res_rw` = 0.
- R10: `done` is high for exactly one cycle per request. A walk issues at most three reads. Each read is a one-cycle `mem_rd_valid` pulse, and the next read is issued only after the previous response has arrived.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle, request can be taken |
| req_addr | input | 64 | DMA address to translate |
| fn_state | input | 2 | Function state (0 standby, 1 disabled, 2 enabled, 3 blocked) |
| xlate_en | input | 1 | Translation enabled for the function |
| win_lo | input | 64 | Lowest allowed DMA address |
| win_hi | input | 64 | Highest allowed DMA address |
| origin | input | 64 | Region-table origin word; low 12 bits are flags |
| mem_rd_valid | output | 1 | One-cycle read request |
| mem_rd_addr | output | 64 | Address of the 8-byte entry to read |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 64 | Returned table entry |
| done | output | 1 | One-cycle result strobe |
| res_page | output | 64 | Translated page address |
| res_mask | output | 64 | Offset mask (0xFFF on success, all ones on fault) |
| res_rw | output | 1 | 1 = read-write, 0 = no permission |

## Verification
The assertions assume that `mem_rsp_valid` arrives only for an outstanding read, and only once for each read. They also assume that the request inputs are stable in the accepting cycle. The bench's memory model answers each one-cycle read pulse with a single response on the next clock. The bench drives requests only while `req_ready` is high and drops `req_valid` right after acceptance. With this stimulus the read-count, read-spacing and gating properties test only the walker itself.

// File: rtl/dxw_pkg.sv
package dxw_pkg;

   typedef enum logic [2:0] {
      W_IDLE,
      W_RT_RD,
      W_RT_WT,
      W_ST_RD,
      W_ST_WT,
      W_PT_RD,
      W_PT_WT,
      W_DONE
   } walk_st_t;

   localparam int unsigned LVL_RT = 0;
   localparam int unsigned LVL_ST = 1;
   localparam int unsigned LVL_PT = 2;

   localparam logic [1:0] TYPE_RT = 2'b11;
   localparam logic [1:0] TYPE_ST = 2'b10;
   localparam int unsigned TYPE_LSB = 2;
   localparam int unsigned INV_BIT  = 10;

endpackage

// File: rtl/dxw_entry_addr.sv
module dxw_entry_addr #(
   parameter int unsigned ADDR_W   = 64,
   parameter int unsigned PG_SHIFT = 12,
   parameter int unsigned PX_BITS  = 8,
   parameter int unsigned SX_BITS  = 11,
   parameter int unsigned RX_BITS  = 11
) (
   input  logic [1:0]        level,
   input  logic [ADDR_W-1:0] va,
   input  logic [ADDR_W-1:0] base,
   output logic [ADDR_W-1:0] entry_addr
);
   localparam int unsigned NLVL = 3;
   localparam int unsigned SX_LSB = PG_SHIFT + PX_BITS;
   localparam int unsigned RX_LSB = SX_LSB + SX_BITS;
   localparam int unsigned LSBS [NLVL]  = '{RX_LSB, SX_LSB, PG_SHIFT};
   localparam int unsigned WIDS [NLVL]  = '{RX_BITS, SX_BITS, PX_BITS};

   logic [ADDR_W-1:0] offs [NLVL];

   for (genvar g = 0; g < NLVL; g++) begin : g_lvl
      logic [WIDS[g]-1:0] idx;
      assign idx = va[LSBS[g] +: WIDS[g]];
      assign offs[g] = ADDR_W'({idx, 3'b000});
   end

   always_comb begin
      case (level)
         2'd0:    entry_addr = base + offs[0];
         2'd1:    entry_addr = base + offs[1];
         default: entry_addr = base + offs[2];
      endcase
   end
endmodule

// File: rtl/dxw_rsp_stage.sv
module dxw_rsp_stage #(
   parameter int unsigned DATA_W  = 64,
   parameter bit          REG_RSP = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_data,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_data
);
   if (REG_RSP) begin : g_reg
      logic              v_q;
      logic [DATA_W-1:0] d_q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            v_q <= 1'b0;
            d_q <= '0;
         end else begin
            v_q <= in_valid;
            if (in_valid) d_q <= in_data;
         end
      end
      assign out_valid = v_q;
      assign out_data  = d_q;
   end else begin : g_pass
      assign out_valid = in_valid;
      assign out_data  = in_data;
   end
endmodule

// File: rtl/dxw_entry_decode.sv
module dxw_entry_decode
   import dxw_pkg::*;
#(
   parameter int unsigned ADDR_W   = 64,
   parameter int unsigned PG_SHIFT = 12
) (
   input  logic [1:0]        level,
   input  logic [ADDR_W-1:0] entry,
   output logic              follow,
   output logic [ADDR_W-1:0] next_ptr,
   output logic              is_zero,
   output logic              rw_ok
);
   localparam logic [ADDR_W-1:0] OFS = ADDR_W'((64'd1 << PG_SHIFT) - 64'd1);

   logic [1:0] etype;
   assign etype = entry[TYPE_LSB +: 2];

   always_comb begin
      case (level)
         2'd0:    follow = (etype == TYPE_RT);
         2'd1:    follow = (etype == TYPE_ST);
         default: follow = 1'b0;
      endcase
   end

   assign next_ptr = entry & ~OFS;
   assign is_zero  = (entry == '0);
   assign rw_ok    = ~entry[INV_BIT];
endmodule

// File: rtl/dma_xlate_walker.sv
module dma_xlate_walker
   import dxw_pkg::*;
#(
   parameter int unsigned ADDR_W   = 64,
   parameter int unsigned PG_SHIFT = 12,
   parameter int unsigned PX_BITS  = 8,
   parameter int unsigned SX_BITS  = 11,
   parameter int unsigned RX_BITS  = 11,
   parameter bit          REG_RSP  = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [1:0]        fn_state,
   input  logic              xlate_en,
   input  logic [ADDR_W-1:0] win_lo,
   input  logic [ADDR_W-1:0] win_hi,
   input  logic [ADDR_W-1:0] origin,
   output logic              mem_rd_valid,
   output logic [ADDR_W-1:0] mem_rd_addr,
   input  logic              mem_rsp_valid,
   input  logic [ADDR_W-1:0] mem_rsp_data,
   output logic              done,
   output logic [ADDR_W-1:0] res_page,
   output logic [ADDR_W-1:0] res_mask,
   output logic              res_rw
);
   localparam int unsigned TOP_BIT = PG_SHIFT + PX_BITS + SX_BITS + RX_BITS;
   localparam logic [ADDR_W-1:0] OFS = ADDR_W'((64'd1 << PG_SHIFT) - 64'd1);

   if (TOP_BIT > ADDR_W) begin : g_bad_width
      $error("index fields exceed the address width");
   end
   if (PG_SHIFT <= INV_BIT) begin : g_bad_page
      $error("page offset must cover the entry flag bits");
   end

   walk_st_t          st_q;
   logic [ADDR_W-1:0] va_q, ptr_q, page_q, mask_q;
   logic              rw_q;
   logic [1:0]        level;
   logic              rsp_v;
   logic [ADDR_W-1:0] rsp_d;
   logic              dec_follow, dec_zero, dec_rw;
   logic [ADDR_W-1:0] dec_ptr;
   logic              gate_ok;

   always_comb begin
      case (st_q)
         W_RT_RD, W_RT_WT: level = 2'd0;
         W_ST_RD, W_ST_WT: level = 2'd1;
         default:          level = 2'd2;
      endcase
   end

   dxw_entry_addr #(
      .ADDR_W(ADDR_W), .PG_SHIFT(PG_SHIFT), .PX_BITS(PX_BITS),
      .SX_BITS(SX_BITS), .RX_BITS(RX_BITS)
   ) u_addr (
      .level(level), .va(va_q), .base(ptr_q), .entry_addr(mem_rd_addr)
   );

   dxw_rsp_stage #(.DATA_W(ADDR_W), .REG_RSP(REG_RSP)) u_rsp (
      .clk(clk), .rst_n(rst_n),
      .in_valid(mem_rsp_valid), .in_data(mem_rsp_data),
      .out_valid(rsp_v), .out_data(rsp_d)
   );

   dxw_entry_decode #(.ADDR_W(ADDR_W), .PG_SHIFT(PG_SHIFT)) u_dec (
      .level(level), .entry(rsp_d), .follow(dec_follow),
      .next_ptr(dec_ptr), .is_zero(dec_zero), .rw_ok(dec_rw)
   );

   assign gate_ok = xlate_en && (fn_state[1] == 1'b1) &&
                    (req_addr >= win_lo) && (req_addr <= win_hi);

   assign req_ready    = (st_q == W_IDLE);
   assign mem_rd_valid = (st_q == W_RT_RD) || (st_q == W_ST_RD) || (st_q == W_PT_RD);
   assign done         = (st_q == W_DONE);
   assign res_page     = page_q;
   assign res_mask     = mask_q;
   assign res_rw       = rw_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q   <= W_IDLE;
         va_q   <= '0;
         ptr_q  <= '0;
         page_q <= '0;
         mask_q <= '1;
         rw_q   <= 1'b0;
      end else begin
         case (st_q)
            W_IDLE: if (req_valid) begin
               va_q   <= req_addr;
               ptr_q  <= origin & ~OFS;
               page_q <= '0;
               mask_q <= '1;
               rw_q   <= 1'b0;
               st_q   <= gate_ok ? W_RT_RD : W_DONE;
            end
            W_RT_RD: st_q <= W_RT_WT;
            W_ST_RD: st_q <= W_ST_WT;
            W_PT_RD: st_q <= W_PT_WT;
            W_RT_WT, W_ST_WT: if (rsp_v) begin
               if (dec_follow) begin
                  ptr_q <= dec_ptr;
                  st_q  <= (st_q == W_RT_WT) ? W_ST_RD : W_PT_RD;
               end else begin
                  st_q  <= W_DONE;
               end
            end
            W_PT_WT: if (rsp_v) begin
               if (!dec_zero) begin
                  page_q <= dec_ptr;
                  mask_q <= OFS;
                  rw_q   <= dec_rw;
               end
               st_q <= W_DONE;
            end
            default: st_q <= W_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/dxw_checker.sv
module dxw_checker #(
   parameter int unsigned ADDR_W   = 64,
   parameter int unsigned PG_SHIFT = 12
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_ready,
   input logic [1:0]        fn_state,
   input logic              xlate_en,
   input logic              mem_rd_valid,
   input logic [ADDR_W-1:0] mem_rd_addr,
   input logic              done,
   input logic [ADDR_W-1:0] res_mask,
   input logic              res_rw
);
   localparam logic [ADDR_W-1:0] OFS = ADDR_W'((64'd1 << PG_SHIFT) - 64'd1);

   logic [2:0] rd_cnt;
   always_ff @(posedge clk) begin
      if (!rst_n)                       rd_cnt <= '0;
      else if (req_valid && req_ready)  rd_cnt <= '0;
      else if (mem_rd_valid && rd_cnt != 3'd7) rd_cnt <= rd_cnt + 3'd1;
   end

   p_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_valid |-> !req_ready);
   p_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && (!xlate_en || !fn_state[1])) |=> !mem_rd_valid);
   p_align_r4: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_valid |-> (mem_rd_addr[2:0] == 3'b000));
   p_ok_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (done && res_rw) |-> (res_mask == OFS));
   p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   p_rd_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_valid |=> !mem_rd_valid);
   p_rd_limit_r10: assert property (@(posedge clk) disable iff (!rst_n)
      rd_cnt <= 3'd3);
endmodule

bind dma_xlate_walker dxw_checker #(.ADDR_W(ADDR_W), .PG_SHIFT(PG_SHIFT)) u_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
   .fn_state(fn_state), .xlate_en(xlate_en), .mem_rd_valid(mem_rd_valid),
   .mem_rd_addr(mem_rd_addr), .done(done), .res_mask(res_mask), .res_rw(res_rw)
);

// File: tb/dma_xlate_walker_tb.sv
module dma_xlate_walker_tb;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   logic        req_valid = 1'b0, req_ready;
   logic [63:0] req_addr = '0, win_lo = '0, win_hi = '1, origin = '0;
   logic [1:0]  fn_state = 2'd2;
   logic        xlate_en = 1'b1;
   logic        mem_rd_valid, mem_rsp_valid = 1'b0;
   logic [63:0] mem_rd_addr, mem_rsp_data = '0;
   logic        done, res_rw;
   logic [63:0] res_page, res_mask;

   dma_xlate_walker u_dut (.*);

   int errors = 0, checks = 0;
   bit finished = 0;
   logic [63:0] mem [logic [63:0]];
   int rd_cnt = 0;
   logic [63:0] rd_addr [3];
   logic [63:0] r_page, r_mask;
   logic r_rw;
   int r_reads;

   always @(posedge clk) begin
      mem_rsp_valid <= 1'b0;
      if (mem_rd_valid) begin
         mem_rsp_valid <= 1'b1;
         mem_rsp_data  <= mem.exists(mem_rd_addr) ? mem[mem_rd_addr] : 64'd0;
         if (rd_cnt < 3) rd_addr[rd_cnt] = mem_rd_addr;
         rd_cnt = rd_cnt + 1;
      end
   end

   task automatic check(string req, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   localparam logic [63:0] ORG = 64'h10000;
   function automatic logic [63:0] mk_va(int rx, int sx, int px);
      return (64'(rx) << 31) | (64'(sx) << 20) | (64'(px) << 12) | 64'habc;
   endfunction

   task automatic xlate(logic [63:0] a, logic [1:0] fs, logic en,
                        logic [63:0] lo, logic [63:0] hi, logic [63:0] org);
      int n = 0;
      @(negedge clk);
      rd_cnt = 0;
      req_addr = a; fn_state = fs; xlate_en = en;
      win_lo = lo; win_hi = hi; origin = org;
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      check("R1 busy after accept", 64'(req_ready), 64'd0);
      while (!done && n < 50) begin
         @(negedge clk);
         n++;
      end
      check("R10 done seen", 64'(done), 64'd1);
      r_page = res_page; r_mask = res_mask; r_rw = res_rw; r_reads = rd_cnt;
      @(negedge clk);
      check("R10 done one cycle", 64'(done), 64'd0);
      check("R1 ready after done", 64'(req_ready), 64'd1);
   endtask

   task automatic expect_fault(string req, int reads);
      check({req, " reads"}, 64'(r_reads), 64'(reads));
      check({"R9 page ", req}, r_page, 64'd0);
      check({"R9 mask ", req}, r_mask, '1);
      check({"R9 perm ", req}, 64'(r_rw), 64'd0);
   endtask

   task automatic t_reset();
      check("R1 reset ready", 64'(req_ready), 64'd1);
      check("R10 reset done", 64'(done), 64'd0);
      check("R10 reset read", 64'(mem_rd_valid), 64'd0);
   endtask

   task automatic t_ok();
      xlate(mk_va(3, 5, 7), 2'd2, 1'b1, 64'd0, '1, ORG | 64'h5);
      check("R10 reads", 64'(r_reads), 64'd3);
      check("R4 region addr", rd_addr[0], ORG + 64'd24);
      check("R5 segment addr", rd_addr[1], 64'h20000 + 64'd40);
      check("R6 page addr", rd_addr[2], 64'h30000 + 64'd56);
      check("R8 page", r_page, 64'hABCDE000);
      check("R8 mask", r_mask, 64'hFFF);
      check("R8 rw", 64'(r_rw), 64'd1);
      xlate(mk_va(3, 5, 7), 2'd3, 1'b1, 64'd0, '1, ORG);
      check("R2 blocked translates", 64'(r_rw), 64'd1);
   endtask

   task automatic t_gate();
      xlate(mk_va(3, 5, 7), 2'd1, 1'b1, 64'd0, '1, ORG);
      expect_fault("R2 disabled", 0);
      xlate(mk_va(3, 5, 7), 2'd0, 1'b1, 64'd0, '1, ORG);
      expect_fault("R2 standby", 0);
      xlate(mk_va(3, 5, 7), 2'd2, 1'b0, 64'd0, '1, ORG);
      expect_fault("R2 xlate off", 0);
   endtask

   task automatic t_window();
      logic [63:0] a = mk_va(3, 5, 7);
      xlate(a, 2'd2, 1'b1, a + 64'd1, '1, ORG);
      expect_fault("R3 below", 0);
      xlate(a, 2'd2, 1'b1, 64'd0, a - 64'd1, ORG);
      expect_fault("R3 above", 0);
      xlate(a, 2'd2, 1'b1, a, a, ORG);
      check("R3 inclusive reads", 64'(r_reads), 64'd3);
      check("R3 inclusive page", r_page, 64'hABCDE000);
   endtask

   task automatic t_invalid();
      xlate(mk_va(3, 5, 9), 2'd2, 1'b1, 64'd0, '1, ORG);
      check("R8 invalid page", r_page, 64'h55555000);
      check("R8 invalid mask", r_mask, 64'hFFF);
      check("R8 invalid perm", 64'(r_rw), 64'd0);
   endtask

   task automatic t_types();
      xlate(mk_va(4, 5, 7), 2'd2, 1'b1, 64'd0, '1, ORG);
      expect_fault("R5 region type", 1);
      xlate(mk_va(3, 6, 7), 2'd2, 1'b1, 64'd0, '1, ORG);
      expect_fault("R6 segment type", 2);
      xlate(mk_va(3, 5, 11), 2'd2, 1'b1, 64'd0, '1, ORG);
      expect_fault("R7 zero pte", 3);
   endtask

   initial begin
      mem[ORG + 64'd24]      = 64'h2000C;
      mem[ORG + 64'd32]      = 64'h30008;
      mem[64'h20000 + 64'd40] = 64'h30008;
      mem[64'h20000 + 64'd48] = 64'h40004;
      mem[64'h30000 + 64'd56] = 64'hABCDE001;
      mem[64'h30000 + 64'd72] = 64'h55555400;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_ok();
      t_gate();
      t_window();
      t_invalid();
      t_types();
      if (!finished) begin
         finished = 1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         checks++;
         errors++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule